// File: doc/BRIEF.md
# Load-use stall detector

This block sits in the decode stage of a five-stage in-order pipeline. It spots the single read-after-write case that operand bypassing cannot repair: a load is now in the execute stage, and the instruction being decoded needs the load's destination register as a source. When it sees this case, it freezes the program counter and the fetch/decode register for that cycle. It also forces the control word headed into the decode/execute register to all zeros. The bubble that results is an ordinary no-op, so the main decoder and the bypass network need no knowledge of the stall.

The block decodes the opcode of the instruction being decoded to find which of its two source fields it really reads. An instruction that reads only its first source is never held because its second field happens to match. The block also holds a small program counter and a fetch/decode register, so the effect of a stall can be seen at the ports. The load's destination register number and its memory-read flag are taken from the decode/execute register as inputs.

Top module: `luh_stall_unit`

## Requirements
- R1: A synchronous active-high reset clears the program counter and the fetch/decode register to zero. The all-zero word decodes as a harmless no-op, so after reset `pc_write`=1, `ifid_write`=1 and `ctrl_zero`=0.
- R2: The decoded word's opcode sits in bits [31:26], its first source in [25:21] and its second source in [20:16]. For opcode 000000 (register ALU), 101011 (store) or 000100 (branch-if-equal), a stall is raised when `idex_mem_read`=1 and `idex_rt` equals either source. A stall means `pc_write`=0, `ifid_write`=0 and `ctrl_zero`=1, all in the same cycle.
- R3: Any other opcode, for example 100011 (load) or 001000 (add-immediate), stalls only when `idex_rt` equals the first source. A match on bits [20:16] alone has no effect.
- R4: Opcodes 000010 and 000011 (jumps) read no register and never stall.
- R5: With `idex_mem_read`=0 there is never a stall.
- R6: With `idex_rt`=0 there is never a stall, whatever the source fields hold.
- R7: `ctrl_out` equals `ctrl_in` when there is no stall and equals zero during a stall.
- R8: At a clock edge where a stall is present, `pc_q` and `ifid_q` keep their values.
- R9: At a clock edge with no stall, `pc_q` advances by 4 and `ifid_q` takes `fetch_instr`.
- R10: The stall outputs are combinational in the current inputs. Once the hazard condition drops, the write enables return to 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_instr | input | 32 | Word fetched at `pc_q`, loaded into the fetch/decode register |
| idex_mem_read | input | 1 | Memory-read flag of the instruction in execute |
| idex_rt | input | 5 | Destination register of the instruction in execute |
| ctrl_in | input | 8 | Control word from the main decoder |
| pc_write | output | 1 | Program counter update enable |
| ifid_write | output | 1 | Fetch/decode register load enable |
| ctrl_zero | output | 1 | Bubble select for the decode/execute control word |
| ctrl_out | output | 8 | Control word after bubble gating |
| pc_q | output | 32 | Program counter |
| ifid_q | output | 32 | Instruction now in decode |

## Verification
The bench goes after the cases where the second source matters only for some opcodes. A design that compares both fields for every instruction would wrongly stall a load or add-immediate whose bits [20:16] match, and one that compares only the first field would miss the store and branch hazards. It also covers register zero as the load destination, jumps carrying matching bit patterns, and a matching register with no load present; a decoder that misses any of these adds false bubbles. Finally, it checks that a stalled edge leaves the counter and decode word untouched, and that the stall ends as soon as the load leaves.

// File: rtl/luh_pkg.sv
package luh_pkg;

    localparam int OP_W    = 6;
    localparam int REG_W   = 5;
    localparam int FIELD_W = OP_W + 2 * REG_W;

    localparam logic [OP_W-1:0] OPC_ALU   = 6'b000000;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OP_W-1:0] OPC_JMP   = 6'b000010;
    localparam logic [OP_W-1:0] OPC_JAL   = 6'b000011;

    // bit 0: first source read, bit 1: second source read
    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_A    = 2'b01,
        SRC_AB   = 2'b11
    } src_class_e;

    typedef struct packed {
        logic b_used;
        logic a_used;
    } src_use_t;

    typedef struct packed {
        logic [REG_W-1:0] a;
        logic [REG_W-1:0] b;
    } src_regs_t;

    typedef struct packed {
        logic pc_write;
        logic ifid_write;
        logic ctrl_zero;
    } stall_ctl_t;

    function automatic src_class_e classify(input logic [OP_W-1:0] op);
        src_class_e c;
        case (op)
            OPC_ALU, OPC_STORE, OPC_BEQ: c = SRC_AB;
            OPC_JMP, OPC_JAL:            c = SRC_NONE;
            default:                     c = SRC_A;
        endcase
        return c;
    endfunction

    function automatic src_use_t class_to_use(input src_class_e c);
        src_use_t u;
        u.a_used = c[0];
        u.b_used = c[1];
        return u;
    endfunction

endpackage

// File: rtl/luh_src_decode.sv
module luh_src_decode
    import luh_pkg::*;
(
    input  logic [FIELD_W-1:0] fields_i,
    output src_use_t           use_o,
    output src_regs_t          regs_o
);
    localparam int OP_LSB = FIELD_W - OP_W;
    localparam int A_LSB  = OP_LSB - REG_W;
    localparam int B_LSB  = A_LSB - REG_W;

    logic [OP_W-1:0] op;
    src_class_e      cls;

    always_comb begin
        op       = fields_i[OP_LSB +: OP_W];
        cls      = classify(op);
        use_o    = class_to_use(cls);
        regs_o.a = fields_i[A_LSB +: REG_W];
        regs_o.b = fields_i[B_LSB +: REG_W];
    end

endmodule

// File: rtl/luh_hazard_cmp.sv
module luh_hazard_cmp
    import luh_pkg::*;
#(
    parameter int LANES = 2
) (
    input  src_use_t         use_i,
    input  src_regs_t        regs_i,
    input  logic             ld_valid,
    input  logic [REG_W-1:0] ld_dst,
    output logic             hazard_o
);
    logic [LANES-1:0][REG_W-1:0] src;
    logic [LANES-1:0]            used;
    logic [LANES-1:0]            hit;

    assign src[0]  = regs_i.a;
    assign src[1]  = regs_i.b;
    assign used[0] = use_i.a_used;
    assign used[1] = use_i.b_used;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign hit[g] = used[g] && (src[g] == ld_dst);
    end

    assign hazard_o = ld_valid && (ld_dst != '0) && (|hit);

endmodule

// File: rtl/luh_front_regs.sv
module luh_front_regs #(
    parameter int PC_W    = 32,
    parameter int INSTR_W = 32,
    parameter int PC_STEP = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pc_en,
    input  logic               ifid_en,
    input  logic [INSTR_W-1:0] fetch_instr,
    output logic [PC_W-1:0]    pc_q,
    output logic [INSTR_W-1:0] ifid_q
);
    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            ifid_q <= '0;
        end else begin
            if (pc_en)   pc_q   <= pc_q + STEP;
            if (ifid_en) ifid_q <= fetch_instr;
        end
    end

endmodule

// File: rtl/luh_stall_unit.sv
module luh_stall_unit
    import luh_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int PC_W    = 32,
    parameter int PC_STEP = 4,
    parameter int CTRL_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] fetch_instr,
    input  logic               idex_mem_read,
    input  logic [REG_W-1:0]   idex_rt,
    input  logic [CTRL_W-1:0]  ctrl_in,
    output logic               pc_write,
    output logic               ifid_write,
    output logic               ctrl_zero,
    output logic [CTRL_W-1:0]  ctrl_out,
    output logic [PC_W-1:0]    pc_q,
    output logic [INSTR_W-1:0] ifid_q
);
    src_use_t   src_use;
    src_regs_t  src_regs;
    logic       hazard;
    stall_ctl_t ctl;

    luh_src_decode u_decode (
        .fields_i (ifid_q[INSTR_W-1 -: FIELD_W]),
        .use_o    (src_use),
        .regs_o   (src_regs)
    );

    luh_hazard_cmp #(.LANES(2)) u_cmp (
        .use_i    (src_use),
        .regs_i   (src_regs),
        .ld_valid (idex_mem_read),
        .ld_dst   (idex_rt),
        .hazard_o (hazard)
    );

    always_comb begin
        ctl.pc_write   = !hazard;
        ctl.ifid_write = !hazard;
        ctl.ctrl_zero  = hazard;
    end

    assign pc_write   = ctl.pc_write;
    assign ifid_write = ctl.ifid_write;
    assign ctrl_zero  = ctl.ctrl_zero;
    assign ctrl_out   = ctl.ctrl_zero ? '0 : ctrl_in;

    luh_front_regs #(
        .PC_W    (PC_W),
        .INSTR_W (INSTR_W),
        .PC_STEP (PC_STEP)
    ) u_front (
        .clk         (clk),
        .rst         (rst),
        .pc_en       (ctl.pc_write),
        .ifid_en     (ctl.ifid_write),
        .fetch_instr (fetch_instr),
        .pc_q        (pc_q),
        .ifid_q      (ifid_q)
    );

endmodule

// File: rtl/luh_stall_unit_chk.sv
module luh_stall_unit_chk
    import luh_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int PC_W    = 32,
    parameter int PC_STEP = 4,
    parameter int CTRL_W  = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               idex_mem_read,
    input logic [REG_W-1:0]   idex_rt,
    input logic               pc_write,
    input logic               ifid_write,
    input logic               ctrl_zero,
    input logic [CTRL_W-1:0]  ctrl_out,
    input logic [PC_W-1:0]    pc_q,
    input logic [INSTR_W-1:0] ifid_q
);
    logic [OP_W-1:0] id_op;
    assign id_op = ifid_q[INSTR_W-1 -: OP_W];

    a_r2_enables_agree: assert property (@(posedge clk) disable iff (rst)
        !ifid_write |-> (!pc_write && ctrl_zero));

    a_r4_jump_never_stalls: assert property (@(posedge clk) disable iff (rst)
        (id_op == OPC_JMP || id_op == OPC_JAL) |-> pc_write);

    a_r5_no_load_no_stall: assert property (@(posedge clk) disable iff (rst)
        !idex_mem_read |-> (pc_write && ifid_write && !ctrl_zero));

    a_r6_zero_dst_no_stall: assert property (@(posedge clk) disable iff (rst)
        (idex_rt == '0) |-> (pc_write && ifid_write));

    a_r7_bubble_is_zero: assert property (@(posedge clk) disable iff (rst)
        ctrl_zero |-> (ctrl_out == '0));

    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        !pc_write |=> ($stable(pc_q) && $stable(ifid_q)));

    a_r9_advance: assert property (@(posedge clk) disable iff (rst)
        pc_write |=> (pc_q == $past(pc_q) + PC_W'(PC_STEP)));

endmodule

bind luh_stall_unit luh_stall_unit_chk #(
    .INSTR_W (INSTR_W),
    .PC_W    (PC_W),
    .PC_STEP (PC_STEP),
    .CTRL_W  (CTRL_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .idex_mem_read (idex_mem_read),
    .idex_rt       (idex_rt),
    .pc_write      (pc_write),
    .ifid_write    (ifid_write),
    .ctrl_zero     (ctrl_zero),
    .ctrl_out      (ctrl_out),
    .pc_q          (pc_q),
    .ifid_q        (ifid_q)
);

// File: tb/luh_stall_unit_bench.sv
module luh_stall_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] CTRL_PAT = 8'hA5;

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] a,
                                       input logic [4:0] b);
        return {op, a, b, 16'h1234};
    endfunction

    typedef struct packed {
        logic [31:0] instr;
        logic        mr;
        logic [4:0]  dst;
        logic        stall;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{mk(6'b000000, 5'd3, 5'd4),  1'b1, 5'd3,  1'b1},  // R2 alu first src
        '{mk(6'b000000, 5'd3, 5'd4),  1'b1, 5'd4,  1'b1},  // R2 alu second src
        '{mk(6'b000000, 5'd3, 5'd4),  1'b1, 5'd5,  1'b0},  // R2 no match
        '{mk(6'b101011, 5'd7, 5'd8),  1'b1, 5'd8,  1'b1},  // R2 store second
        '{mk(6'b000100, 5'd1, 5'd2),  1'b1, 5'd2,  1'b1},  // R2 branch second
        '{mk(6'b000100, 5'd1, 5'd2),  1'b1, 5'd1,  1'b1},  // R2 branch first
        '{mk(6'b100011, 5'd9, 5'd10), 1'b1, 5'd10, 1'b0},  // R3 load b ignored
        '{mk(6'b100011, 5'd9, 5'd10), 1'b1, 5'd9,  1'b1},  // R3 load a
        '{mk(6'b001000, 5'd6, 5'd11), 1'b1, 5'd11, 1'b0},  // R3 addi b ignored
        '{mk(6'b001000, 5'd6, 5'd11), 1'b1, 5'd6,  1'b1},  // R3 addi a
        '{mk(6'b000010, 5'd5, 5'd5),  1'b1, 5'd5,  1'b0},  // R4 jump
        '{mk(6'b000011, 5'd5, 5'd5),  1'b1, 5'd5,  1'b0},  // R4 jal
        '{mk(6'b000000, 5'd3, 5'd4),  1'b0, 5'd3,  1'b0},  // R5 no load
        '{mk(6'b000000, 5'd0, 5'd0),  1'b1, 5'd0,  1'b0},  // R6 zero dst
        '{mk(6'b101011, 5'd0, 5'd8),  1'b1, 5'd0,  1'b0}   // R6 zero dst store
    };
    string vtag [NV] = '{"R2", "R2", "R2", "R2", "R2", "R2", "R3", "R3", "R3", "R3",
                         "R4", "R4", "R5", "R6", "R6"};

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] fetch_instr;
    logic        idex_mem_read;
    logic [4:0]  idex_rt;
    logic [7:0]  ctrl_in;
    logic        pc_write, ifid_write, ctrl_zero;
    logic [7:0]  ctrl_out;
    logic [31:0] pc_q, ifid_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    luh_stall_unit u_luh_stall_unit (
        .clk           (clk),
        .rst           (rst),
        .fetch_instr   (fetch_instr),
        .idex_mem_read (idex_mem_read),
        .idex_rt       (idex_rt),
        .ctrl_in       (ctrl_in),
        .pc_write      (pc_write),
        .ifid_write    (ifid_write),
        .ctrl_zero     (ctrl_zero),
        .ctrl_out      (ctrl_out),
        .pc_q          (pc_q),
        .ifid_q        (ifid_q)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] pc_before, id_before;
        rst           = 1'b1;
        fetch_instr   = '0;
        idex_mem_read = 1'b0;
        idex_rt       = '0;
        ctrl_in       = CTRL_PAT;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", 64'(pc_q), 64'd0);
        chk("R1", 64'(ifid_q), 64'd0);
        chk("R1", 64'({pc_write, ifid_write, ctrl_zero}), 64'(3'b110));

        // table walk: load the word into decode, then present the load in execute
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idex_mem_read = 1'b0;
            fetch_instr   = VEC[i].instr;
            @(posedge clk);
            @(negedge clk);
            fetch_instr   = 32'hFFFF_FFFF;
            idex_mem_read = VEC[i].mr;
            idex_rt       = VEC[i].dst;
            #1;
            chk(vtag[i], 64'({pc_write, ifid_write, ctrl_zero}),
                64'({~VEC[i].stall, ~VEC[i].stall, VEC[i].stall}));
            chk("R7", 64'(ctrl_out), VEC[i].stall ? 64'd0 : 64'(CTRL_PAT));
        end

        // R8: stall holds counter and decode word across an edge
        @(negedge clk);
        idex_mem_read = 1'b0;
        fetch_instr   = mk(6'b000000, 5'd12, 5'd13);
        @(posedge clk);
        @(negedge clk);
        idex_mem_read = 1'b1;
        idex_rt       = 5'd13;
        fetch_instr   = 32'hDEAD_BEEF;
        #1;
        pc_before = pc_q;
        id_before = ifid_q;
        chk("R2", 64'(ctrl_zero), 64'd1);
        @(posedge clk);
        @(negedge clk);
        chk("R8", 64'(pc_q), 64'(pc_before));
        chk("R8", 64'(ifid_q), 64'(id_before));
        // R10: load leaves, stall drops in the same cycle
        idex_mem_read = 1'b0;
        #1;
        chk("R10", 64'({pc_write, ifid_write, ctrl_zero}), 64'(3'b110));
        chk("R7", 64'(ctrl_out), 64'(CTRL_PAT));
        // R9: next edge advances and loads
        @(posedge clk);
        @(negedge clk);
        chk("R9", 64'(pc_q), 64'(pc_before + 32'd4));
        chk("R9", 64'(ifid_q), 64'h0000_0000_DEAD_BEEF);

        // R1 again: reset mid-run clears state
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", 64'(pc_q), 64'd0);
        chk("R1", 64'(ifid_q), 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule